// File: doc/BRIEF.md
# Serial Transceiver with Stop-Bit-Framed Word Length

This block is an asynchronous serial transmitter and receiver. Each side has a single-entry holding buffer. Software writes a transmit word whose low bits carry the data. One or two `1` stop bits sit above the data, and zeros fill the rest of the word. The transmitter finds the highest set bit of the word and uses it as the frame length. It sends a low start bit, then every bit of the word from bit 0 up to and including that highest set bit, and then returns the line to its high idle level. A word waits in the holding buffer until the shift register has finished the previous frame.

The receiver oversamples the line with a 16x baud tick. It confirms a start bit at its midpoint, then samples each following bit at its centre. A mode input selects 8 or 9 data bits. A completed frame goes into the receive buffer and raises a full flag. If a frame completes while that flag is still set, the overrun flag is raised and the new frame is thrown away. A single read word packs the status flags, the live receive pin and the received bits side by side. A clear input releases the buffer for the next frame.

Top module: `uart_sbf`

## Requirements
- R1: After reset `txd_o` is high and `rd_data_o` reads 16'h3800 while `rxd_i` is high. In that value bit 13 (transmit buffer empty) and bit 12 (transmit shifter empty) are set, and all other flags and data bits are clear.
- R2: A write of a nonzero word loads the holding buffer, and bit 13 reads 0 on the next cycle. A write of an all-zero word is ignored: bit 13 stays 1 and `txd_o` stays high.
- R3: When the holding buffer is full and the shifter is empty, the word moves to the shifter one cycle later, setting bit 13 and clearing bit 12. While a frame is in progress, a newly written word waits and bit 13 stays 0.
- R4: A frame is a low start bit followed by the word's bits LSB first, up to and including its highest set bit. Each bit lasts 16 baud ticks. After the last bit the line is high and bit 12 reads 1 unless another word is waiting.
- R5: With `rx_long_i` = 0, a frame carries 8 data bits and one stop bit. The read word then holds the data in bits 7..0 and the received stop bit in both bit 8 and bit 9.
- R6: With `rx_long_i` = 1, a frame carries 9 data bits and one stop bit. The read word then holds the data in bits 8..0 and the received stop bit in bit 9.
- R7: A low pulse on `rxd_i` shorter than half a bit period does not start a frame and does not set bit 14.
- R8: Completion of a frame loads the receive bits and sets bit 14 (receive buffer full).
- R9: If a frame completes while bit 14 is set, bit 15 (overrun) sets and bits 9..0 keep the earlier frame.
- R10: A pulse on `rbf_clr_i` clears both bit 14 and bit 15.
- R11: Bit 11 follows the `rxd_i` pin directly, with no clock delay, and bit 10 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| tx_wr_i | input | 1 | Transmit word write strobe |
| tx_wdata_i | input | 16 | Transmit word: data, then stop bit(s), then zeros |
| rx_long_i | input | 1 | Receive 9 data bits when 1, 8 when 0 |
| rbf_clr_i | input | 1 | Clear receive-full and overrun flags |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line, idles high |
| rd_data_o | output | 16 | Status and receive data word |

## Verification
The hardest state to reach is a second word waiting in the holding buffer while the shifter is still mid-frame, because the transfer must then happen exactly at the end of the first frame. The bench writes two words back to back and decodes both frames from `txd_o` in sequence, checking the flags between them. Overrun needs two complete frames with no clear in between, so the bench drives the receive line directly for two frames and reads the word only after the second. Random frames are looped from `txd_o` back to `rxd_i`, so frame lengths set by the stop-bit position are checked on both sides.

// File: rtl/uart_sbf_pkg.sv
package uart_sbf_pkg;
  localparam int WORD_W = 16;
  localparam int LEFT_W = $clog2(WORD_W + 2);
  localparam int RX_W   = 10;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA} rx_state_e;

  // index of the highest set bit; 0 for an all-zero word
  function automatic logic [LEFT_W-1:0] top_set_idx(logic [WORD_W-1:0] w);
    logic [LEFT_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (w[i]) idx = LEFT_W'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/uart_sbf_tx.sv
module uart_sbf_tx
  import uart_sbf_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              tbe_o,
  output logic              tsre_o,
  output logic              txd_o
);
  localparam int CNT_W = $clog2(OSR);

  logic [WORD_W-1:0] hold_q;
  logic [WORD_W:0]   sh_q;
  logic [LEFT_W-1:0] left_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              tbe_q, tsre_q;
  logic              load_req, xfer;

  assign load_req = wr_i && (wdata_i != '0);
  assign xfer     = !tbe_q && tsre_q && !load_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      sh_q   <= '0;
      left_q <= '0;
      cnt_q  <= '0;
      tbe_q  <= 1'b1;
      tsre_q <= 1'b1;
    end else begin
      if (load_req) begin
        hold_q <= wdata_i;
        tbe_q  <= 1'b0;
      end else if (xfer) begin
        sh_q   <= {hold_q, 1'b0};
        left_q <= top_set_idx(hold_q) + LEFT_W'(2);
        cnt_q  <= '0;
        tbe_q  <= 1'b1;
        tsre_q <= 1'b0;
      end
      if (!tsre_q && tick_i) begin
        if (cnt_q == CNT_W'(OSR - 1)) begin
          cnt_q  <= '0;
          sh_q   <= sh_q >> 1;
          left_q <= left_q - LEFT_W'(1);
          if (left_q == LEFT_W'(1)) tsre_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign tbe_o  = tbe_q;
  assign tsre_o = tsre_q;
  assign txd_o  = tsre_q | sh_q[0];

  assert_zero_write_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i == '0 && tbe_q) |=> tbe_q);
  assert_transfer_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tbe_q && tsre_q && !wr_i) |=> (tbe_q && !tsre_q));
  assert_wait_while_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tbe_q && !tsre_q) |=> !tbe_q);
  assert_last_bit_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tsre_q) |-> $past(txd_o));
endmodule

// File: rtl/uart_sbf_rx.sv
module uart_sbf_rx
  import uart_sbf_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            rxd_i,
  input  logic            long_i,
  input  logic            clr_i,
  output logic [RX_W-1:0] rbuf_o,
  output logic            rbf_o,
  output logic            ovrun_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int HALF  = OSR / 2;

  rx_state_e        state_q;
  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       nbit_q;
  logic [RX_W-1:0]  sh_q, sh_nx, frame_c, rbuf_q;
  logic             long_q, rbf_q, ovrun_q;
  logic             line, bit_end, done_c;

  assign line    = sync_q[1];
  assign bit_end = (state_q == RX_DATA) && tick_i && (cnt_q == CNT_W'(OSR - 1));
  assign done_c  = bit_end && (nbit_q == (long_q ? 4'd9 : 4'd8));
  assign sh_nx   = {line, sh_q[RX_W-1:1]};
  // short frame: nine samples land in [9:1]; stop bit is repeated in bit 9
  assign frame_c = long_q ? sh_nx : {sh_nx[RX_W-1], sh_nx[RX_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      nbit_q  <= '0;
      sh_q    <= '0;
      long_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      if (tick_i) begin
        unique case (state_q)
          RX_IDLE: if (!line) begin
            state_q <= RX_START;
            cnt_q   <= '0;
            long_q  <= long_i;
          end
          RX_START: begin
            if (cnt_q == CNT_W'(HALF - 1)) begin
              cnt_q  <= '0;
              nbit_q <= '0;
              state_q <= line ? RX_IDLE : RX_DATA;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          RX_DATA: begin
            if (bit_end) begin
              cnt_q  <= '0;
              sh_q   <= sh_nx;
              nbit_q <= nbit_q + 4'd1;
              if (done_c) state_q <= RX_IDLE;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbuf_q  <= '0;
      rbf_q   <= 1'b0;
      ovrun_q <= 1'b0;
    end else begin
      if (clr_i) begin
        rbf_q   <= 1'b0;
        ovrun_q <= 1'b0;
      end
      if (done_c) begin
        if (rbf_q && !clr_i) begin
          ovrun_q <= 1'b1;
        end else begin
          rbuf_q <= frame_c;
          rbf_q  <= 1'b1;
        end
      end
    end
  end

  assign rbuf_o  = rbuf_q;
  assign rbf_o   = rbf_q;
  assign ovrun_o = ovrun_q;

  assert_load_sets_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_c && !rbf_q) |=> rbf_q);
  assert_overrun_keeps_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_c && rbf_q && !clr_i) |=> (ovrun_q && $stable(rbuf_q)));
  assert_clear_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !done_c) |=> (!rbf_q && !ovrun_q));
  assert_reject_short_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_START && tick_i && cnt_q == CNT_W'(HALF - 1) && line) |=> state_q == RX_IDLE);
endmodule

// File: rtl/uart_sbf.sv
module uart_sbf
  import uart_sbf_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        baud_tick_i,
  input  logic        tx_wr_i,
  input  logic [15:0] tx_wdata_i,
  input  logic        rx_long_i,
  input  logic        rbf_clr_i,
  input  logic        rxd_i,
  output logic        txd_o,
  output logic [15:0] rd_data_o
);
  logic            tbe, tsre, rbf, ovrun;
  logic [RX_W-1:0] rbuf;

  uart_sbf_tx #(.OSR(OSR)) i_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (baud_tick_i),
    .wr_i    (tx_wr_i),
    .wdata_i (tx_wdata_i),
    .tbe_o   (tbe),
    .tsre_o  (tsre),
    .txd_o   (txd_o)
  );

  uart_sbf_rx #(.OSR(OSR)) i_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (baud_tick_i),
    .rxd_i   (rxd_i),
    .long_i  (rx_long_i),
    .clr_i   (rbf_clr_i),
    .rbuf_o  (rbuf),
    .rbf_o   (rbf),
    .ovrun_o (ovrun)
  );

  assign rd_data_o = {ovrun, rbf, tbe, tsre, rxd_i, 1'b0, rbuf};

  always_comb begin
    assert_bit10_zero_R11: assert (!rst_ni || rd_data_o[10] == 1'b0);
  end
endmodule

// File: tb/test_uart_sbf.sv
module test_uart_sbf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  tdiv = '0;
  logic        tick;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic        rx_long = 1'b0;
  logic        clr = 1'b0;
  logic        rxd_drv = 1'b1;
  logic        loop_en = 1'b0;
  logic        rxd;
  logic        txd;
  logic [15:0] rd;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;
  always @(negedge clk) tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd0);
  assign rxd  = loop_en ? txd : rxd_drv;

  uart_sbf i_uart_sbf (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .tx_wr_i(wr),
    .tx_wdata_i(wdata), .rx_long_i(rx_long), .rbf_clr_i(clr),
    .rxd_i(rxd), .txd_o(txd), .rd_data_o(rd)
  );

  localparam int BIT_CLK = 64;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int msb_of(input logic [15:0] w);
    int m = 0;
    for (int i = 0; i < 16; i++) if (w[i]) m = i;
    return m;
  endfunction

  function automatic logic [9:0] exp_rx(input logic [8:0] d, input bit lng, input bit stp);
    return lng ? {stp, d} : {stp, stp, d[7:0]};
  endfunction

  task automatic write_word(input logic [15:0] w);
    wr = 1'b1; wdata = w;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic pulse_clr();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  // decode one frame from txd and compare with the word (R4)
  task automatic tx_expect(input logic [15:0] w, input bit idle_chk);
    int m = msb_of(w);
    while (txd) @(negedge clk);
    clks(BIT_CLK / 2);
    chk(txd == 1'b0, "R4 start bit", 32'(txd), 32'd0);
    for (int i = 0; i <= m; i++) begin
      clks(BIT_CLK);
      chk(txd == w[i], "R4 data bit", 32'(txd), 32'(w[i]));
    end
    if (idle_chk) begin
      clks(BIT_CLK);
      chk(txd == 1'b1 && rd[12], "R4 idle after frame", {30'd0, rd[12], txd}, 32'd3);
    end
  endtask

  task automatic send_rx(input logic [8:0] d, input bit lng, input bit stp);
    rxd_drv = 1'b0;
    clks(BIT_CLK);
    for (int i = 0; i < (lng ? 9 : 8); i++) begin
      rxd_drv = d[i];
      clks(BIT_CLK);
    end
    rxd_drv = stp;
    clks(BIT_CLK);
    rxd_drv = 1'b1;
    clks(BIT_CLK);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    clks(3);
    @(negedge clk) rst_n = 1'b1;
    clks(2);
    // R1
    chk(rd == 16'h3800, "R1 reset read word", 32'(rd), 32'h3800);
    chk(txd == 1'b1, "R1 txd idle", 32'(txd), 32'd1);

    // R2: zero write ignored
    write_word(16'h0000);
    chk(rd[13] && rd[12], "R2 zero write flags", 32'(rd[13:12]), 32'd3);
    for (int k = 0; k < 4; k++) begin
      clks(40);
      chk(txd == 1'b1, "R2 zero write line", 32'(txd), 32'd1);
    end

    // R2/R3/R4: back-to-back words
    fork
      begin
        tx_expect(16'h01A5, 1'b0);
        tx_expect(16'h0337, 1'b1);
      end
      begin
        wr = 1'b1; wdata = 16'h01A5;
        @(negedge clk);
        wr = 1'b0;
        chk(rd[13] == 1'b0, "R2 holding loaded", 32'(rd[13]), 32'd0);
        @(negedge clk);
        chk(rd[13:12] == 2'b10, "R3 transfer flags", 32'(rd[13:12]), 32'd2);
        write_word(16'h0337);
        chk(rd[13] == 1'b0, "R3 second word waits", 32'(rd[13]), 32'd0);
        clks(300);
        chk(rd[13:12] == 2'b00, "R3 busy flags", 32'(rd[13:12]), 32'd0);
      end
    join
    chk(rd[13:12] == 2'b11, "R3 both empty", 32'(rd[13:12]), 32'd3);

    // R11: live pin, bit 10 zero
    rxd_drv = 1'b0;
    #1;
    chk(rd[11] == 1'b0 && rd[10] == 1'b0, "R11 live low", 32'(rd[11:10]), 32'd0);
    rxd_drv = 1'b1;
    #1;
    chk(rd[11] == 1'b1 && rd[10] == 1'b0, "R11 live high", 32'(rd[11:10]), 32'd2);
    clks(100);

    // R7: short low pulses rejected
    rxd_drv = 1'b0; clks(16); rxd_drv = 1'b1; clks(128);
    chk(rd[14] == 1'b0, "R7 glitch 4 ticks", 32'(rd[14]), 32'd0);
    rxd_drv = 1'b0; clks(20); rxd_drv = 1'b1; clks(128);
    chk(rd[14] == 1'b0, "R7 glitch 5 ticks", 32'(rd[14]), 32'd0);

    // R5/R8: short frame, R9 overrun, R10 clear
    rx_long = 1'b0;
    send_rx(9'h0C3, 1'b0, 1'b1);
    chk(rd[14] == 1'b1, "R8 full after frame", 32'(rd[14]), 32'd1);
    chk(rd[9:0] == exp_rx(9'h0C3, 1'b0, 1'b1), "R5 short frame", 32'(rd[9:0]), 32'(exp_rx(9'h0C3, 1'b0, 1'b1)));
    send_rx(9'h05A, 1'b0, 1'b1);
    chk(rd[15] == 1'b1, "R9 overrun set", 32'(rd[15]), 32'd1);
    chk(rd[9:0] == exp_rx(9'h0C3, 1'b0, 1'b1), "R9 data kept", 32'(rd[9:0]), 32'(exp_rx(9'h0C3, 1'b0, 1'b1)));
    pulse_clr();
    chk(rd[15:14] == 2'b00, "R10 flags cleared", 32'(rd[15:14]), 32'd0);

    // R6: long frame with directed stop values
    rx_long = 1'b1;
    send_rx(9'h1F0, 1'b1, 1'b1);
    chk(rd[9:0] == exp_rx(9'h1F0, 1'b1, 1'b1), "R6 long frame", 32'(rd[9:0]), 32'(exp_rx(9'h1F0, 1'b1, 1'b1)));
    pulse_clr();

    // R5/R6: random direct frames, stop bit random
    for (int n = 0; n < 12; n++) begin
      logic [8:0] d = 9'($urandom);
      bit lng = 1'($urandom);
      bit stp = 1'($urandom);
      rx_long = lng;
      send_rx(d, lng, stp);
      clks(BIT_CLK);
      chk(rd[9:0] == exp_rx(d, lng, stp), lng ? "R6 random frame" : "R5 random frame",
          32'(rd[9:0]), 32'(exp_rx(d, lng, stp)));
      chk(rd[14] && !rd[15], "R8 full no overrun", 32'(rd[15:14]), 32'd1);
      pulse_clr();
    end

    // R4/R5/R6: random loopback, length set by stop-bit position
    loop_en = 1'b1;
    for (int n = 0; n < 20; n++) begin
      int kind = int'($urandom % 3);
      logic [8:0] d = 9'($urandom);
      logic [15:0] w;
      logic [9:0] e;
      bit lng;
      if (kind == 0) begin w = {7'd0, 1'b1, d[7:0]}; lng = 1'b0; e = exp_rx(d, 1'b0, 1'b1); end
      else if (kind == 1) begin w = {6'd0, 2'b11, d[7:0]}; lng = 1'b0; e = exp_rx(d, 1'b0, 1'b1); end
      else begin w = {6'd0, 1'b1, d}; lng = 1'b1; e = exp_rx(d, 1'b1, 1'b1); end
      rx_long = lng;
      write_word(w);
      tx_expect(w, 1'b1);
      clks(8);
      chk(rd[9:0] == e, "R8 loopback word", 32'(rd[9:0]), 32'(e));
      pulse_clr();
      clks(BIT_CLK);
    end
    loop_en = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule